// File: doc/BRIEF.md
# Sticky Interrupt Status Collector

This block gathers a vector of independent interrupt sources into one sticky status register that software reads. For each source, software picks a detection mode: a rising edge, a falling edge, or the level being high. Each source also has an enable bit. An enabled source that sees its chosen condition sets its status bit. The bit then stays set until the status register is read.

Reading the status register returns the bits and clears them in the same operation. There is one exception: a bit whose source is in level mode and is still high sets itself again straight away. A single interrupt line is active while any status bit is set. Its polarity is chosen by a parameter.

The register interface is a 2-bit address with single-cycle write and read strobes. The 2-bit mode code of each source is split across two registers. The high half sits in one register and the low half in another, both at the same bit position as the source.

Top module: `sticky_irq_collector`

## Requirements
- R1: An enabled source whose condition is detected sets its status bit. The bit is visible one clock later and stays 1 through any number of cycles until the status register is read.
- R2: A read at address 0 returns the status bits during the read cycle. From the next cycle, every bit reads 0, except bits whose event is detected in the same cycle as the read; those bits are kept.
- R3: A level-mode source that is still high when its status is read keeps its status bit at 1 after the read.
- R4: Mode code {high register bit i, low register bit i} selects the detection for source i: 00 rising edge, 01 falling edge, 10 level high. The high half is written at address 2 and the low half at address 3.
- R5: Mode code 11 never sets the status bit of its source.
- R6: When a source's enable bit (address 1, bit i) is 0, the source never sets its status bit, and the bit reads 0. This includes a bit that was already set when the enable bit was cleared.
- R7: The interrupt output is active whenever any status bit is 1 and inactive otherwise. Active means low when IRQ_ACTIVE_LOW=1 (the default) and high when IRQ_ACTIVE_LOW=0.
- R8: After reset, the status, enable and both mode registers read 0x00 and the interrupt output is inactive.
- R9: Address 0 reads the status, 1 the enable mask, 2 the high mode half, 3 the low mode half. Read data is valid in the cycle of the read strobe. A write to address 0 changes nothing.
- R10: Edges are found by comparing each source with its value sampled at the previous clock, and that sampled value is 0 after reset. A source that holds steady produces no further edge events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Interrupt source levels |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| wdata_i | input | N_SRC | Write data |
| rdata_o | output | N_SRC | Read data for the selected register |
| irq_o | output | 1 | Interrupt output, polarity per IRQ_ACTIVE_LOW |

## Verification
The bench builds two copies with N_SRC=8 that share all inputs. One copy keeps the default active-low interrupt and the other sets IRQ_ACTIVE_LOW=0, so both output polarities are checked against the same status history. With eight sources, each bit can be given its own mode or enable case, so edge, level, reserved, disabled and same-cycle read cases run side by side without disturbing one another.

// File: rtl/sticky_irq_collector.sv
module sticky_irq_collector #(
  parameter int N_SRC          = 8,
  parameter bit IRQ_ACTIVE_LOW = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] rdata_o,
  output logic             irq_o
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_MHI  = 2'd2;
  localparam logic [1:0] A_MLO  = 2'd3;

  logic [N_SRC-1:0] stat_q, mask_q, mhi_q, mlo_q, src_q;
  logic [N_SRC-1:0] hit, evt, mask_d, stat_d, lvl_hit, rsv;
  logic             clr;

  for (genvar i = 0; i < N_SRC; i++) begin : g_det
    always_comb begin
      unique case ({mhi_q[i], mlo_q[i]})
        2'b00:   hit[i] = src_i[i] & ~src_q[i];
        2'b01:   hit[i] = ~src_i[i] & src_q[i];
        2'b10:   hit[i] = src_i[i];
        default: hit[i] = 1'b0;
      endcase
    end
  end

  assign evt    = hit & mask_q;
  assign clr    = rd_i && (addr_i == A_STAT);
  assign mask_d = (wr_i && addr_i == A_MASK) ? wdata_i : mask_q;
  assign stat_d = ((clr ? '0 : stat_q) | evt) & mask_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      mhi_q  <= '0;
      mlo_q  <= '0;
      src_q  <= '0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      src_q  <= src_i;
      if (wr_i && addr_i == A_MHI) mhi_q <= wdata_i;
      if (wr_i && addr_i == A_MLO) mlo_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_STAT:  rdata_o = stat_q;
      A_MASK:  rdata_o = mask_q;
      A_MHI:   rdata_o = mhi_q;
      default: rdata_o = mlo_q;
    endcase
  end

  assign irq_o = IRQ_ACTIVE_LOW ? ~(|stat_q) : (|stat_q);

  assign lvl_hit = mask_q & src_i & mhi_q & ~mlo_q;
  assign rsv     = mhi_q & mlo_q;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R1
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0 && !wr_i) |=> (stat_q == '0)); // R2
  AST_LEVEL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr_i) |=> ((stat_q & $past(lvl_hit)) == $past(lvl_hit))); // R3
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ((stat_q & $past(rsv & ~stat_q)) == '0)); // R5
  AST_IRQ_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (irq_o == !IRQ_ACTIVE_LOW)); // R7
  AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_STAT && !rd_i && evt == '0) |=> $stable(stat_q)); // R9
endmodule

// File: tb/sticky_irq_collector_tb.sv
module sticky_irq_collector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0, wdata = '0;
  logic [1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [N-1:0] rdata, rdata_h;
  logic irq_n, irq_h;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sticky_irq_collector #(.N_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_n));
  sticky_irq_collector #(.N_SRC(N), .IRQ_ACTIVE_LOW(1'b0)) dut_h (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata_h), .irq_o(irq_h));

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic set_src(input int b, input logic v);
    @(negedge clk); src[b] = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], d); check("R8 reg reset", d, '0);
    end
    check("R8 irq_n idle", {7'd0, irq_n}, 8'h01);
    check("R8 irq_h idle", {7'd0, irq_h}, 8'h00);
  endtask

  task automatic t_rising();
    logic [N-1:0] d;
    wr_reg(2'd1, 8'hFF); rd_reg(2'd1, d); check("R9 mask readback", d, 8'hFF);
    set_src(0, 1'b1);
    repeat (5) @(negedge clk);
    check("R7 irq_n active", {7'd0, irq_n}, 8'h00);
    check("R7 irq_h active", {7'd0, irq_h}, 8'h01);
    rd_reg(2'd0, d); check("R1 rising sticky", d, 8'h01);
    rd_reg(2'd0, d); check("R10 steady high no re-trigger", d, 8'h00);
    check("R7 irq_n idle after clear", {7'd0, irq_n}, 8'h01);
    check("R7 irq_h idle after clear", {7'd0, irq_h}, 8'h00);
  endtask

  task automatic t_falling();
    logic [N-1:0] d;
    wr_reg(2'd3, 8'h02); rd_reg(2'd3, d); check("R9 mode low readback", d, 8'h02);
    set_src(1, 1'b1); rd_reg(2'd0, d); check("R4 falling ignores rise", d, 8'h00);
    set_src(1, 1'b0); rd_reg(2'd0, d); check("R4 falling sets", d, 8'h02);
  endtask

  task automatic t_level();
    logic [N-1:0] d;
    wr_reg(2'd2, 8'h04);
    set_src(2, 1'b1);
    rd_reg(2'd0, d); check("R4 level sets", d, 8'h04);
    rd_reg(2'd0, d); check("R3 level held after read", d, 8'h04);
    set_src(2, 1'b0);
    rd_reg(2'd0, d); check("R3 sticky after drop", d, 8'h04);
    rd_reg(2'd0, d); check("R2 cleared", d, 8'h00);
  endtask

  task automatic t_reserved();
    logic [N-1:0] d;
    wr_reg(2'd2, 8'h0C); wr_reg(2'd3, 8'h0A);
    set_src(3, 1'b1); set_src(3, 1'b0);
    rd_reg(2'd0, d); check("R5 reserved code", d, 8'h00);
  endtask

  task automatic t_mask();
    logic [N-1:0] d;
    wr_reg(2'd1, 8'hEF);
    set_src(4, 1'b1);
    rd_reg(2'd0, d); check("R6 disabled source", d, 8'h00);
    set_src(5, 1'b1);
    wr_reg(2'd1, 8'hCF);
    rd_reg(2'd0, d); check("R6 disable clears bit", d, 8'h00);
    wr_reg(2'd1, 8'hFF);
  endtask

  task automatic t_read_race();
    logic [N-1:0] d;
    @(negedge clk); addr = 2'd0; rd = 1'b1; src[6] = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
    check("R2 read before event", d, 8'h00);
    rd_reg(2'd0, d); check("R2 event kept on read", d, 8'h40);
  endtask

  task automatic t_status_write();
    logic [N-1:0] d;
    set_src(7, 1'b1);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, d); check("R9 status write ignored", d, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rising();
    t_falling();
    t_level();
    t_reserved();
    t_mask();
    t_read_race();
    t_status_write();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule